// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of a two-input, 8-bit successive-approximation converter that a host drives over a three-wire serial link. The host pulls the active-low select line down and clocks the link. It shifts in a start bit followed by a two-bit word that picks the input configuration. The block then steers the external analog multiplexer and runs a binary search against an external resistor ladder and comparator. The ladder is driven from `trial_o`, and the comparator answers on `cmp_i`.

Each result bit leaves on the data line as soon as the comparator decides it, so the code comes out most significant bit first. After that stream the block sends the same code again in the opposite order. Bit 0 is sent only once and serves as the turning point between the two streams. Internal state moves on the rising clock edge, and the data line changes on the falling edge, so the host has half a period of setup before it samples. Data in is only looked at while addressing, which lets the data in and data out pins share one wire.

Top module: `ssar_ctrl`

## Requirements
- R1: With `cs_ni` high, `dout_oe_o` is low at once. Any rising edge with `cs_ni` high returns the block to idle. After that a new transaction works normally, even if the previous one was cut short.
- R2: In idle, each rising edge samples `din_i`, and low bits are skipped. The first high bit is the start bit. The data line stays disabled throughout addressing.
- R3: The two bits after the start bit are, in order, `sgl` and then `odd`. Outputs: `pos_ch_o` = `odd` (0 = channel 0 positive, 1 = channel 1 positive), and `neg_gnd_o` = `sgl` (1 = negative input tied to ground, 0 = the other channel is negative).
- R4: At the falling edge after the `odd` bit is sampled, `dout_oe_o` rises and `dout_o` drives a low settling bit for one period.
- R5: The search takes one period per bit, from bit 7 down to bit 0. `trial_o` is the bits decided so far, with the bit under test set and the lower bits zero. A bit is kept when `cmp_i` is high at the closing rising edge (input at or above the ladder) and cleared otherwise. Outside the search, `trial_o` is zero.
- R6: The eight result bits follow the settling bit on `dout_o`, MSB first, one per period. The last of them (bit 0) is the final search decision.
- R7: Right after bit 0, bits 1 through 7 are sent in that order, one per period.
- R8: From the end of addressing until `cs_ni` rises, `din_i` has no effect on the result or the output stream.
- R9: After bit 7 of the reversed stream, `dout_oe_o` falls at the next falling edge. It stays low, with `trial_o` zero, for any further clocks while `cs_ni` stays low.
- R10: If the comparator stays low on every trial (positive input below negative input), the result is 0x00 in both streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low; high clears the transaction |
| din_i | input | 1 | Serial start and configuration bits |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the ladder |
| dout_o | output | 1 | Serial result bit |
| dout_oe_o | output | 1 | Output enable for the data pad |
| trial_o | output | W (8) | Code driven onto the resistor ladder |
| pos_ch_o | output | 1 | Channel routed to the positive comparator input |
| neg_gnd_o | output | 1 | Negative comparator input tied to ground |

## Verification
The bench models the ladder and comparator around the block and checks every serial bit against the analog value it chose. A design off by one period in its pipeline would shift the whole stream by one bit. Sending bit 0 twice at the turn would push bit 7 past the window where the output is enabled. Codes 0x00, 0xFF, 0x80 and 0x01 catch search bits that are set or cleared in the wrong order. A comparator held low checks that a negative input still yields zero. Random data in during conversion would corrupt the result if the link were not locked out. The bench also cuts a transaction short by raising select mid-search; any state that select fails to clear then shows up in the next transaction.

// File: rtl/ssar_pkg.sv
package ssar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SGL,
    ST_ODD,
    ST_RUN,
    ST_DONE
  } ssar_state_e;
endpackage

// File: rtl/ssar_seq.sv
module ssar_seq
  import ssar_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(2 * W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              din_i,
  output ssar_state_e       state_o,
  output logic [SW-1:0]     step_o,
  output logic              sgl_o,
  output logic              odd_o
);
  localparam logic [SW-1:0] LAST = SW'(2 * W - 1);

  ssar_state_e state_q;
  logic [SW-1:0] step_q;
  logic sgl_q, odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
    end else if (cs_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (din_i) state_q <= ST_SGL;
        ST_SGL: begin
          sgl_q   <= din_i;
          state_q <= ST_ODD;
        end
        ST_ODD: begin
          odd_q   <= din_i;
          step_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (step_q == LAST) state_q <= ST_DONE;
          else step_q <= step_q + 1'b1;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
  assign sgl_o   = sgl_q;
  assign odd_o   = odd_q;

  // R2: the first high bit starts addressing; low bits leave idle unchanged
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cs_ni) |=> (state_q == (($past(din_i)) ? ST_SGL : ST_IDLE)));

  // R8: once running, data in cannot divert the sequence
  p_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !cs_ni) |=> (state_q == ST_RUN || state_q == ST_DONE));

  // R9: finished transactions stay finished until select rises
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !cs_ni) |=> (state_q == ST_DONE));

  // R1: select high returns to idle
  p_cs_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ssar_sar.sv
module ssar_sar
  import ssar_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(2 * W),
  localparam int IW = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  ssar_state_e       state_i,
  input  logic [SW-1:0]     step_i,
  input  logic              cmp_i,
  output logic [W-1:0]      trial_o,
  output logic [W-1:0]      res_o
);
  logic [W-1:0] res_q;
  logic [SW-1:0] bit_idx;
  logic searching;

  assign searching = (state_i == ST_RUN) && (step_i < SW'(W));
  assign bit_idx   = SW'(W - 1) - step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else if (cs_ni || state_i == ST_ODD) res_q <= '0;
    else if (searching) res_q[bit_idx[IW-1:0]] <= cmp_i;
  end

  assign trial_o = searching ? (res_q | (W'(1) << bit_idx[IW-1:0])) : '0;
  assign res_o   = res_q;

  // R5: each search step adds exactly the comparator decision
  p_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (searching && !cs_ni) |=> ($countones(res_q) == $past($countones(res_q)) + int'($past(cmp_i))));

  // R7: the code is frozen while the reversed copy is sent
  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && step_i > SW'(W)) |-> $stable(res_q));
endmodule

// File: rtl/ssar_tx.sv
module ssar_tx
  import ssar_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(2 * W),
  localparam int IW = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  ssar_state_e       state_i,
  input  logic [SW-1:0]     step_i,
  input  logic [W-1:0]      res_i,
  output logic              dout_o,
  output logic              oe_o
);
  logic dout_q, oe_q, nxt_bit;
  logic [SW-1:0] fwd_idx, rev_idx;

  assign fwd_idx = SW'(W) - step_i;
  assign rev_idx = step_i - SW'(W);

  always_comb begin
    if (step_i == '0) nxt_bit = 1'b0;
    else if (step_i <= SW'(W)) nxt_bit = res_i[fwd_idx[IW-1:0]];
    else nxt_bit = res_i[rev_idx[IW-1:0]];
  end

  // launch on the falling edge: half a period of setup for the host
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_ni || state_i != ST_RUN) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      dout_q <= nxt_bit;
      oe_q   <= 1'b1;
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;

  // R4: settling period drives a low bit with the pad enabled
  p_settle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && step_i == '0 && !cs_ni && $past(!cs_ni)) |-> (oe_q && !dout_q));

  // R1: select held high keeps the pad released
  p_cs_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni) && cs_ni) |-> !oe_q);

  // R9: finished transaction keeps the pad released
  p_idle_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DONE && $past(state_i) == ST_DONE) |-> !oe_q);
endmodule

// File: rtl/ssar_ctrl.sv
module ssar_ctrl
  import ssar_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(2 * W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         din_i,
  input  logic         cmp_i,
  output logic         dout_o,
  output logic         dout_oe_o,
  output logic [W-1:0] trial_o,
  output logic         pos_ch_o,
  output logic         neg_gnd_o
);
  ssar_state_e state;
  logic [SW-1:0] step;
  logic sgl, odd, oe;
  logic [W-1:0] res;

  ssar_seq #(.W(W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din_i),
    .state_o(state), .step_o(step), .sgl_o(sgl), .odd_o(odd)
  );

  ssar_sar #(.W(W)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .state_i(state),
    .step_i(step), .cmp_i(cmp_i), .trial_o(trial_o), .res_o(res)
  );

  ssar_tx #(.W(W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .state_i(state),
    .step_i(step), .res_i(res), .dout_o(dout_o), .oe_o(oe)
  );

  // releasing select floats the pad without waiting for a clock
  assign dout_oe_o = oe & ~cs_ni;
  assign pos_ch_o  = odd;
  assign neg_gnd_o = sgl;
endmodule

// File: tb/ssar_ctrl_bench.sv
module ssar_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic din_i = 1'b0;
  logic cmp_i;
  logic dout_o, dout_oe_o, pos_ch_o, neg_gnd_o;
  logic [W-1:0] trial_o;
  logic [W-1:0] vin = '0;
  logic neg_in = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // analog model: input at or above ladder, forced low for a reversed input pair
  assign cmp_i = neg_in ? 1'b0 : (vin >= trial_o);

  ssar_ctrl #(.W(W)) u_ssar_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din_i), .cmp_i(cmp_i),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .trial_o(trial_o),
    .pos_ch_o(pos_ch_o), .neg_gnd_o(neg_gnd_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
    end
  endtask

  // drive a bit, let one rising edge consume it, sample after the next falling edge
  task automatic cyc(input logic d);
    din_i = d;
    @(posedge clk);
    @(negedge clk);
    #(CLK_PERIOD / 4);
  endtask

  function automatic logic [W-1:0] exp_trial(input logic [W-1:0] code, input int k);
    logic [W-1:0] upper = W'(8'hFF << (W - k));
    return (code & upper) | (W'(1) << (W - 1 - k));
  endfunction

  task automatic xact(input int lead, input bit sgl, input bit odd,
                      input logic [W-1:0] v, input bit neg, input int abort_at);
    logic [W-1:0] exp;
    exp = neg ? '0 : v;
    vin = v;
    neg_in = neg;
    cs_ni = 1'b0;
    for (int i = 0; i < lead; i++) begin
      cyc(1'b0);
      chk("R2 idle zeros", dout_oe_o, 0);
    end
    cyc(1'b1);
    chk("R2 start", dout_oe_o, 0);
    cyc(sgl);
    chk("R2 addr", dout_oe_o, 0);
    cyc(odd);
    chk("R4 settle oe", dout_oe_o, 1);
    chk("R4 settle bit", dout_o, 0);
    chk("R3 pos", pos_ch_o, odd);
    chk("R3 gnd", neg_gnd_o, sgl);
    chk("R5 trial msb", trial_o, exp_trial(exp, 0));
    for (int k = 1; k <= W; k++) begin
      cyc(1'($urandom_range(0, 1)));
      if (abort_at == k) begin
        cs_ni = 1'b1;
        #1;
        chk("R1 abort oe", dout_oe_o, 0);
        cyc(1'b0);
        cyc(1'b0);
        return;
      end
      chk("R6 oe", dout_oe_o, 1);
      chk(neg ? "R10 msb-first" : "R6 msb-first", dout_o, exp[W - k]);
      if (k < W) chk("R5 trial", trial_o, exp_trial(exp, k));
    end
    for (int j = 1; j < W; j++) begin
      cyc(1'($urandom_range(0, 1)));
      chk("R7 oe", dout_oe_o, 1);
      chk(neg ? "R10 lsb-first" : "R7 lsb-first", dout_o, exp[j]);
    end
    cyc(1'($urandom_range(0, 1)));
    chk("R9 release", dout_oe_o, 0);
    for (int j = 0; j < 3; j++) begin
      cyc(1'($urandom_range(0, 1)));
      chk("R9 extra oe", dout_oe_o, 0);
      chk("R9 extra trial", trial_o, 0);
    end
    cs_ni = 1'b1;
    #1;
    chk("R1 cs high", dout_oe_o, 0);
    cyc(1'b0);
    cyc(1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_ni = 1'b1;
    #(CLK_PERIOD / 4);
    chk("R1 reset oe", dout_oe_o, 0);
    chk("R5 reset trial", trial_o, 0);
    cyc(1'b0);
    // directed corners
    xact(0, 1'b0, 1'b0, 8'h00, 1'b0, -1);
    xact(2, 1'b0, 1'b1, 8'hFF, 1'b0, -1);
    xact(1, 1'b1, 1'b0, 8'h80, 1'b0, -1);
    xact(3, 1'b1, 1'b1, 8'h01, 1'b0, -1);
    xact(0, 1'b0, 1'b0, 8'hA5, 1'b1, -1);    // R10 reversed inputs
    xact(1, 1'b1, 1'b1, 8'h5A, 1'b0, 4);     // R1 abort mid-search
    xact(0, 1'b0, 1'b1, 8'h3C, 1'b0, -1);    // R1 recovery after abort
    for (int n = 0; n < 30; n++) begin
      xact(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           W'($urandom_range(0, 255)), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, W)) : -1);
    end
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule